// File: doc/BRIEF.md
# Multi-Cycle Integer Core (RV32I Subset)

This block is a small processor core that executes a subset of the RV32I base integer instructions. Every instruction has a fetch phase and an execute phase. Both use a single synchronous word memory port. The same port carries instruction fetches and data loads, and a flag tells the two apart. The core holds a program counter and a 32 x 32-bit register file. Entry zero of the register file is hardwired to zero.

The supported instructions are:
- the two upper-immediate forms, LUI and AUIPC;
- the direct and register-indirect jumps with link, JAL and JALR;
- the six register-immediate operations: ADDI, SLTI, SLTIU, XORI, ORI and ANDI;
- the five loads: LB, LH, LW, LBU and LHU.

Any other encoding stops the core for good, and so does a fetch from an address that is not a multiple of four. The core is meant as a bring-up or housekeeping sequencer that runs short code out of a local memory.

The control is a five-state machine:
- `ST_FETCH` drives the program counter onto the port. It moves to `ST_IWAIT`, or to `ST_HALT` when the program counter is misaligned.
- `ST_IWAIT` captures the returned word as the current instruction and moves to `ST_EXEC`.
- `ST_EXEC` decodes the instruction and does one of three things. For an illegal encoding it moves to `ST_HALT`. For a load it issues the data read and moves to `ST_LWAIT`. For anything else it writes the result and the next program counter and returns to `ST_FETCH`.
- `ST_LWAIT` extends the returned data, writes it to the register file, steps the program counter and returns to `ST_FETCH`.
- `ST_HALT` never exits except by reset.

An ALU instruction therefore takes three cycles and a load takes four.

Top module: `mini_rv_core`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0 and the state to fetch. In the first cycle after reset the port shows a fetch read (`mem_rd`=1, `mem_fetch`=1) at address 0, and `halted` is 0.
- R2: Register x0 always reads as zero, and any result written to x0 is discarded.
- R3: A fetch reads the word at the program counter. Read data returns on `mem_rdata` in the cycle after the read cycle. Every instruction other than JAL and JALR moves the program counter forward by 4.
- R4: LUI (opcode 0110111) writes instruction bits 31:12 into bits 31:12 of rd and zeros into bits 11:0. AUIPC (opcode 0010111) writes the instruction's own address plus that same value.
- R5: JAL (opcode 1101111) builds a 21-bit offset from instruction bits: offset[20]=ir[31], offset[10:1]=ir[30:21], offset[11]=ir[20], offset[19:12]=ir[19:12], and offset[0]=0. The offset is sign-extended from bit 20. The jump target is pc + offset, and rd receives pc + 4.
- R6: JALR (opcode 1100111, funct3 000) jumps to rs1 + sign-extended imm[11:0] with bit 0 of the sum forced to 0. rd receives pc + 4.
- R7: ADDI, XORI, ORI and ANDI (opcode 0010011, funct3 000, 100, 110, 111) combine rs1 with the 12-bit immediate in ir[31:20], sign-extended.
- R8: SLTI (funct3 010) writes 1 when rs1 < imm as signed numbers. SLTIU (funct3 011) writes 1 when the same comparison holds with both operands unsigned. Otherwise each writes 0.
- R9: A load (opcode 0000011) reads at byte address rs1 + sign-extended imm, presented in full on `mem_addr` with `mem_fetch`=0. Memory is little-endian: a byte comes from the lane given by address bits 1:0, a halfword from bits [16*addr[1] +: 16], and a word ignores address bits 1:0.
- R10: LB (funct3 000) and LH (001) sign-extend to 32 bits. LBU (100) and LHU (101) zero-extend. LW is funct3 010.
- R11: Any opcode or funct3 outside those listed in R4 to R10 stops the core. `halted` rises and stays high, the program counter freezes, and no further memory read is issued until reset.
- R12: A fetch from a program counter whose bits 1:0 are not 00 stops the core in the same way, without issuing the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Memory read request this cycle |
| mem_fetch | output | 1 | High when the read is an instruction fetch |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_rd` |
| halted | output | 1 | Core stopped by an illegal instruction or misaligned fetch |

## Verification
The register file has no port of its own, so register contents are the hardest thing to see from outside. The stimulus exposes them through the memory port: after each instruction under test, a load into x0 whose base is the register of interest puts that register's exact value on `mem_addr`, and the discarded load result leaves every other register untouched. The J-type bit reordering is reached with offsets that exercise bits 19:12 and bit 11 in both signs. The targets are chosen so that they alias onto empty memory words, and the fetched address then shows the computed target before the core stops.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;
    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_IWAIT,
        ST_EXEC,
        ST_LWAIT,
        ST_HALT
    } core_state_t;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_OR,
        ALU_AND,
        ALU_PASSB
    } alu_op_t;

    typedef enum logic [1:0] { FMT_I, FMT_U, FMT_J } imm_fmt_t;
    typedef enum logic [1:0] { WB_ALU, WB_LINK, WB_LOAD } wb_sel_t;
    typedef enum logic [1:0] { PC_SEQ, PC_JAL, PC_JALR } pc_sel_t;
    typedef enum logic [1:0] { LD_B, LD_H, LD_W } ld_size_t;

    typedef struct packed {
        logic     legal;
        logic     rd_we;
        wb_sel_t  wb;
        pc_sel_t  pcs;
        imm_fmt_t fmt;
        alu_op_t  op;
        logic     a_pc;
        logic     is_load;
        ld_size_t lsz;
        logic     lzx;
    } ctl_t;

endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
    import mini_core_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        case (opcode)
            OPC_LUI: begin
                ctl.legal = 1'b1;
                ctl.rd_we = 1'b1;
                ctl.fmt   = FMT_U;
                ctl.op    = ALU_PASSB;
            end
            OPC_AUIPC: begin
                ctl.legal = 1'b1;
                ctl.rd_we = 1'b1;
                ctl.fmt   = FMT_U;
                ctl.op    = ALU_ADD;
                ctl.a_pc  = 1'b1;
            end
            OPC_JAL: begin
                ctl.legal = 1'b1;
                ctl.rd_we = 1'b1;
                ctl.wb    = WB_LINK;
                ctl.pcs   = PC_JAL;
                ctl.fmt   = FMT_J;
                ctl.op    = ALU_ADD;
                ctl.a_pc  = 1'b1;
            end
            OPC_JALR: begin
                ctl.legal = (funct3 == 3'b000);
                ctl.rd_we = 1'b1;
                ctl.wb    = WB_LINK;
                ctl.pcs   = PC_JALR;
                ctl.fmt   = FMT_I;
                ctl.op    = ALU_ADD;
            end
            OPC_LOAD: begin
                ctl.rd_we   = 1'b1;
                ctl.wb      = WB_LOAD;
                ctl.fmt     = FMT_I;
                ctl.op      = ALU_ADD;
                ctl.is_load = 1'b1;
                case (funct3)
                    3'b000: begin ctl.legal = 1'b1; ctl.lsz = LD_B; end
                    3'b001: begin ctl.legal = 1'b1; ctl.lsz = LD_H; end
                    3'b010: begin ctl.legal = 1'b1; ctl.lsz = LD_W; end
                    3'b100: begin ctl.legal = 1'b1; ctl.lsz = LD_B; ctl.lzx = 1'b1; end
                    3'b101: begin ctl.legal = 1'b1; ctl.lsz = LD_H; ctl.lzx = 1'b1; end
                    default: ctl.legal = 1'b0;
                endcase
            end
            OPC_OPIMM: begin
                ctl.rd_we = 1'b1;
                ctl.fmt   = FMT_I;
                ctl.legal = 1'b1;
                case (funct3)
                    3'b000:  ctl.op = ALU_ADD;
                    3'b010:  ctl.op = ALU_SLT;
                    3'b011:  ctl.op = ALU_SLTU;
                    3'b100:  ctl.op = ALU_XOR;
                    3'b110:  ctl.op = ALU_OR;
                    3'b111:  ctl.op = ALU_AND;
                    default: ctl.legal = 1'b0;
                endcase
            end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc_immgen.sv
module mc_immgen
    import mini_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:12]    ir_hi,
    input  imm_fmt_t        fmt,
    output logic [XLEN-1:0] imm
);

    localparam int I_EXT = XLEN - 12;
    localparam int U_EXT = XLEN - 31;
    localparam int J_EXT = XLEN - 21;

    logic [XLEN-1:0] imm_i, imm_u, imm_j;

    assign imm_i = {{I_EXT{ir_hi[31]}}, ir_hi[31:20]};
    assign imm_u = {{U_EXT{ir_hi[31]}}, ir_hi[30:12], 12'b0};
    // bit 20 of the offset sits at ir[31]; the rest are scattered
    assign imm_j = {{J_EXT{ir_hi[31]}}, ir_hi[31], ir_hi[19:12], ir_hi[20],
                    ir_hi[30:21], 1'b0};

    always_comb begin
        case (fmt)
            FMT_U:   imm = imm_u;
            FMT_J:   imm = imm_j;
            default: imm = imm_i;
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mini_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_t         op,
    output logic [XLEN-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SLT:   y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU:  y = XLEN'(a < b);
            ALU_XOR:   y = a ^ b;
            ALU_OR:    y = a | b;
            ALU_AND:   y = a & b;
            ALU_PASSB: y = b;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/mc_loadext.sv
module mc_loadext
    import mini_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] word,
    input  logic [1:0]      lane,
    input  ld_size_t        lsz,
    input  logic            lzx,
    output logic [XLEN-1:0] y
);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    assign byte_v = word[{lane, 3'b000} +: 8];
    assign half_v = word[{lane[1], 4'b0000} +: 16];

    always_comb begin
        case (lsz)
            LD_B:    y = lzx ? XLEN'(byte_v) : {{(XLEN-8){byte_v[7]}}, byte_v};
            LD_H:    y = lzx ? XLEN'(half_v) : {{(XLEN-16){half_v[15]}}, half_v};
            default: y = word;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [XLEN-1:0]         wdata,
    input  logic [$clog2(NREG)-1:0] raddr,
    output logic [XLEN-1:0]         rdata
);

    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] rd_vec [NREG];

    assign rd_vec[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_row
        logic [XLEN-1:0] q;
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) begin
                q <= wdata;
            end
        end
        assign rd_vec[g] = q;
    end

    assign rdata = rd_vec[raddr];

    // a write aimed at x0 leaves x0 reading zero
    p_x0_discard_r2: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0 && raddr == '0) |=> (rdata == '0));

    // a write to another register is visible on the next read
    p_wr_visible_r7: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0 && raddr == waddr) |=>
            ($stable(raddr) -> rdata == $past(wdata)));

endmodule

// File: rtl/mini_rv_core.sv
module mini_rv_core
    import mini_core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_rd,
    output logic            mem_fetch,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted
);

    localparam int AW = $clog2(NREG);

    core_state_t     state_q, state_d;
    logic [XLEN-1:0] pc_q, ir_q;
    logic [XLEN-1:0] pc_plus4, next_pc, imm, alu_a, alu_y, ld_val, wb_val, rs1_val;
    logic            rf_we;
    ctl_t            ctl;

    mc_decoder u_dec (
        .opcode (ir_q[6:0]),
        .funct3 (ir_q[14:12]),
        .ctl    (ctl)
    );

    mc_immgen #(.XLEN(XLEN)) u_imm (
        .ir_hi (ir_q[31:12]),
        .fmt   (ctl.fmt),
        .imm   (imm)
    );

    mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (ir_q[7+AW-1:7]),
        .wdata (wb_val),
        .raddr (ir_q[15+AW-1:15]),
        .rdata (rs1_val)
    );

    assign alu_a = ctl.a_pc ? pc_q : rs1_val;

    mc_alu #(.XLEN(XLEN)) u_alu (
        .a  (alu_a),
        .b  (imm),
        .op (ctl.op),
        .y  (alu_y)
    );

    mc_loadext #(.XLEN(XLEN)) u_ld (
        .word (mem_rdata),
        .lane (alu_y[1:0]),
        .lsz  (ctl.lsz),
        .lzx  (ctl.lzx),
        .y    (ld_val)
    );

    assign pc_plus4 = pc_q + XLEN'(4);

    always_comb begin
        case (ctl.pcs)
            PC_JAL:  next_pc = alu_y;
            PC_JALR: next_pc = {alu_y[XLEN-1:1], 1'b0};
            default: next_pc = pc_plus4;
        endcase
    end

    always_comb begin
        case (ctl.wb)
            WB_LINK: wb_val = pc_plus4;
            WB_LOAD: wb_val = ld_val;
            default: wb_val = alu_y;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = (pc_q[1:0] != 2'b00) ? ST_HALT : ST_IWAIT;
            ST_IWAIT: state_d = ST_EXEC;
            ST_EXEC: begin
                if (!ctl.legal)       state_d = ST_HALT;
                else if (ctl.is_load) state_d = ST_LWAIT;
                else                  state_d = ST_FETCH;
            end
            ST_LWAIT: state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // state register with program counter and instruction
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IWAIT) begin
                ir_q <= mem_rdata;
            end
            if (state_q == ST_EXEC && ctl.legal && !ctl.is_load) begin
                pc_q <= next_pc;
            end else if (state_q == ST_LWAIT) begin
                pc_q <= pc_plus4;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_fetch = 1'b0;
        mem_addr  = pc_q;
        rf_we     = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                if (pc_q[1:0] == 2'b00) begin
                    mem_rd    = 1'b1;
                    mem_fetch = 1'b1;
                end
            end
            ST_EXEC: begin
                if (ctl.legal && ctl.is_load) begin
                    mem_rd   = 1'b1;
                    mem_addr = alu_y;
                end else if (ctl.legal) begin
                    rf_we = ctl.rd_we;
                end
            end
            ST_LWAIT: begin
                rf_we    = 1'b1;
                mem_addr = alu_y;
            end
            default: ;
        endcase
    end

    assign halted = (state_q == ST_HALT);

    p_fetch_aligned_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_fetch) |-> (mem_addr[1:0] == 2'b00));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q)));

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_rd);

    p_jalr_even_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ctl.legal && ctl.pcs == PC_JALR) |=> !pc_q[0]);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ctl.legal && !ctl.is_load && ctl.pcs == PC_SEQ)
            |=> (pc_q == $past(pc_q) + XLEN'(4)));

    p_fetch_reply_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_fetch) |=> (state_q == ST_IWAIT));

endmodule

// File: tb/test_mini_rv_core.sv
module test_mini_rv_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd, mem_fetch, halted;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] flog [64];
    logic [31:0] dlog [64];
    int          fcnt = 0;
    int          dcnt = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mini_rv_core i_mini_rv_core (
        .clk       (clk),
        .rst       (rst),
        .mem_rd    (mem_rd),
        .mem_fetch (mem_fetch),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(negedge clk) begin
        if (rst) begin
            fcnt = 0;
            dcnt = 0;
        end else if (mem_rd) begin
            if (mem_fetch) begin
                if (fcnt < 64) flog[fcnt] = mem_addr;
                fcnt = fcnt + 1;
            end else begin
                if (dcnt < 64) dlog[dcnt] = mem_addr;
                dcnt = dcnt + 1;
            end
        end
    end

    function automatic logic [31:0] e_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] e_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
        return {imm, rd, op};
    endfunction

    function automatic logic [31:0] e_j(logic [20:0] off, logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] peek(logic [4:0] rs);
        return e_i(12'h000, rs, 3'b010, 5'd0, 7'b0000011);
    endfunction

    function automatic logic [31:0] opi(logic [2:0] f3, logic [4:0] rd, logic [4:0] rs, logic [11:0] imm);
        return e_i(imm, rs, f3, rd, 7'b0010011);
    endfunction

    function automatic logic [31:0] ld(logic [2:0] f3, logic [4:0] rd, logic [4:0] rs, logic [11:0] imm);
        return e_i(imm, rs, f3, rd, 7'b0000011);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    endtask

    task automatic start_core();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4) rst = 1'b0;
    endtask

    task automatic wait_halt(input string req);
        int fc, dc;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        chk(req, "halted", 32'(halted), 32'h1);
        fc = fcnt;
        dc = dcnt;
        repeat (20) @(negedge clk);
        chk("R11", "no fetch after halt", 32'(fcnt), 32'(fc));
        chk("R11", "no load after halt", 32'(dcnt), 32'(dc));
    endtask

    task automatic t_reset();
        clear_mem();
        start_core();
        @(negedge clk);
        chk("R1", "mem_rd", 32'(mem_rd), 32'h1);
        chk("R1", "mem_fetch", 32'(mem_fetch), 32'h1);
        chk("R1", "mem_addr", mem_addr, 32'h0);
        chk("R1", "halted", 32'(halted), 32'h0);
        wait_halt("R11");
        chk("R11", "opcode 0 fetch count", 32'(fcnt), 32'd1);
        chk("R1", "first fetch", flog[0], 32'h0);
    endtask

    task automatic t_upper();
        clear_mem();
        mem[0] = e_u(20'hABCDE, 5'd1, 7'b0110111);
        mem[1] = e_u(20'h00012, 5'd2, 7'b0010111);
        mem[2] = peek(5'd1);
        mem[3] = peek(5'd2);
        start_core();
        wait_halt("R4");
        chk("R4", "LUI value", dlog[0], 32'hABCDE000);
        chk("R4", "AUIPC value", dlog[1], 32'h00012004);
        chk("R3", "fetch count", 32'(fcnt), 32'd5);
        for (int i = 0; i < 5; i++) chk("R3", "sequential fetch", flog[i], 32'(4 * i));
    endtask

    task automatic t_opimm();
        logic [31:0] exp [9];
        clear_mem();
        mem[0]  = opi(3'b000, 5'd1, 5'd0, 12'hFFB);
        mem[1]  = opi(3'b010, 5'd2, 5'd1, 12'hFFC);
        mem[2]  = opi(3'b011, 5'd3, 5'd1, 12'h005);
        mem[3]  = opi(3'b011, 5'd4, 5'd1, 12'hFFC);
        mem[4]  = opi(3'b010, 5'd8, 5'd1, 12'hFFA);
        mem[5]  = opi(3'b100, 5'd5, 5'd1, 12'h0F0);
        mem[6]  = opi(3'b110, 5'd6, 5'd0, 12'h7FF);
        mem[7]  = opi(3'b111, 5'd7, 5'd1, 12'hFF0);
        mem[8]  = opi(3'b000, 5'd0, 5'd0, 12'h007);
        mem[9]  = peek(5'd1);
        mem[10] = peek(5'd2);
        mem[11] = peek(5'd3);
        mem[12] = peek(5'd4);
        mem[13] = peek(5'd8);
        mem[14] = peek(5'd5);
        mem[15] = peek(5'd6);
        mem[16] = peek(5'd7);
        mem[17] = peek(5'd0);
        mem[18] = ld(3'b010, 5'd0, 5'd0, 12'h004);
        exp = '{32'hFFFFFFFB, 32'h1, 32'h0, 32'h1, 32'h0,
                32'hFFFFFF0B, 32'h000007FF, 32'hFFFFFFF0, 32'h0};
        start_core();
        wait_halt("R7");
        for (int i = 0; i < 9; i++) begin
            if (i >= 1 && i <= 4) chk("R8", "set-less-than", dlog[i], exp[i]);
            else if (i == 8)      chk("R2", "x0 after ADDI", dlog[i], exp[i]);
            else                  chk("R7", "imm op", dlog[i], exp[i]);
        end
        chk("R2", "x0 after load into x0", dlog[9], 32'h4);
    endtask

    task automatic t_loads();
        logic [31:0] ea [9];
        logic [31:0] ev [9];
        logic [2:0]  f3 [9];
        logic [11:0] of [9];
        clear_mem();
        mem[8'h80] = 32'h8081F27F;
        f3 = '{3'b000, 3'b000, 3'b100, 3'b001, 3'b101, 3'b001, 3'b010, 3'b100, 3'b000};
        of = '{12'd0, 12'd1, 12'd1, 12'd2, 12'd2, 12'd0, 12'd3, 12'd3, 12'd3};
        ev = '{32'h0000007F, 32'hFFFFFFF2, 32'h000000F2, 32'hFFFF8081, 32'h00008081,
               32'hFFFFF27F, 32'h8081F27F, 32'h00000080, 32'hFFFFFF80};
        mem[0] = opi(3'b000, 5'd10, 5'd0, 12'h200);
        for (int i = 0; i < 9; i++) begin
            mem[1 + i]  = ld(f3[i], 5'(i + 1), 5'd10, of[i]);
            mem[10 + i] = peek(5'(i + 1));
            ea[i] = 32'h200 + 32'(of[i]);
        end
        start_core();
        wait_halt("R9");
        for (int i = 0; i < 9; i++) begin
            chk("R9", "load address", dlog[i], ea[i]);
            chk("R10", "loaded value", dlog[9 + i], ev[i]);
        end
    endtask

    task automatic t_jal();
        clear_mem();
        mem[0] = e_j(21'd16, 5'd1);
        mem[1] = peek(5'd1);
        mem[2] = peek(5'd2);
        mem[4] = e_j(-21'sd12, 5'd2);
        start_core();
        wait_halt("R5");
        chk("R5", "forward target", flog[1], 32'd16);
        chk("R5", "backward target", flog[2], 32'd4);
        chk("R5", "link forward", dlog[0], 32'd4);
        chk("R5", "link backward", dlog[1], 32'd20);
        chk("R3", "fetch after jump", flog[3], 32'd8);
        // large positive offset hitting bits 19:12 and 11
        clear_mem();
        mem[0] = e_j(21'h55AAC, 5'd3);
        start_core();
        wait_halt("R5");
        chk("R5", "wide positive target", flog[1], 32'h00055AAC);
        // negative offset, target wraps below zero
        clear_mem();
        mem[0] = e_j(-21'sd12532, 5'd3);
        start_core();
        wait_halt("R5");
        chk("R5", "negative target", flog[1], 32'hFFFFCF0C);
    endtask

    task automatic t_jalr();
        clear_mem();
        mem[0]  = opi(3'b000, 5'd5, 5'd0, 12'h033);
        mem[1]  = e_i(12'h00E, 5'd5, 3'b000, 5'd6, 7'b1100111);
        mem[16] = peek(5'd6);
        start_core();
        wait_halt("R6");
        chk("R6", "odd sum cleared", flog[2], 32'h40);
        chk("R6", "link", dlog[0], 32'h8);
        // target with bit 1 set: no fetch is issued
        clear_mem();
        mem[0] = opi(3'b000, 5'd5, 5'd0, 12'h052);
        mem[1] = e_i(12'h000, 5'd5, 3'b000, 5'd0, 7'b1100111);
        start_core();
        wait_halt("R12");
        chk("R12", "fetches before stop", 32'(fcnt), 32'd2);
    endtask

    task automatic t_illegal();
        clear_mem();
        mem[0] = opi(3'b000, 5'd1, 5'd0, 12'h004);
        mem[1] = opi(3'b001, 5'd1, 5'd1, 12'h001);
        mem[2] = peek(5'd1);
        start_core();
        wait_halt("R11");
        chk("R11", "shift funct3 stops", 32'(fcnt), 32'd2);
        chk("R11", "no data access", 32'(dcnt), 32'd0);
        clear_mem();
        mem[0] = ld(3'b011, 5'd1, 5'd0, 12'h000);
        mem[1] = peek(5'd0);
        start_core();
        wait_halt("R11");
        chk("R11", "load funct3 011 stops", 32'(fcnt), 32'd1);
        chk("R11", "no load issued", 32'(dcnt), 32'd0);
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_upper();
        t_opimm();
        t_loads();
        t_jal();
        t_jalr();
        t_illegal();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule